// File: doc/BRIEF.md
# Up-Counting Overflow Event Timer

This block is a 32-bit timer that counts upward and signals an event each time its count passes all-ones. A tick scheduler programs a delay by writing all-ones minus the desired cycle count as the start value, so the event time is set by the distance to overflow rather than by a down-count to zero. For one-shot use the timer stops itself at the event. For periodic use a separately held reload value is put back into the counter at every overflow, and counting goes on.

Software reaches the timer through a single-cycle register port: a valid strobe, a write flag, a word address and write data, with registered read data one cycle later. Writes to the start value and to the run/auto-reload control word pass through a fixed three-cycle pipeline before they act on the counter. Writes to the reload value, the interrupt enable and the status register act at once. The overflow flag is write-one-to-clear, and the interrupt line is a registered AND of that flag and its enable.

Top module: `gp_evt_timer`

## Requirements
- R1: After synchronous reset the count, control word, reload value, interrupt enable and overflow flag all read 0, and irq_o is low.
- R2: While running, the count grows by one each cycle; a read of the COUNT word (address 3) returns the live value and has no side effect, so two back-to-back reads differ by exactly 1.
- R3: With run set (CTRL bit 0) and auto-reload clear (CTRL bit 1), a start value of 0xFFFFFFFF-N gives an overflow N+1 running cycles later; the timer then stops with a count of 0. Counted from the clock edge that accepts the CTRL write issued the cycle after the start-value write, irq_o rises N+5 edges later.
- R4: With auto-reload set, an overflow copies the RELOAD word (address 2) into the count and counting continues, so a reload value of 0xFFFFFFFF-(P-1) gives overflows exactly P cycles apart.
- R5: A write to the LOAD word (address 1) or CTRL word (address 0) accepted at edge k changes the counter state at edge k+3; read data is registered, so reads accepted at edges k+1 to k+3 return the old count and a read at edge k+4 returns the new one. No counting happens on the edge where such a write takes effect.
- R6: A CTRL write with bit 0 clear halts counting once it takes effect and leaves the count unchanged.
- R7: Writing the STATUS word (address 5) with bit 0 set clears the overflow flag (read in bit 0); writing it with bit 0 clear has no effect.
- R8: When a flag clear and a new overflow fall on the same edge, the flag stays set.
- R9: irq_o is high one cycle after the overflow flag and the enable (IEN word, address 4, bit 0) are both set, and low one cycle after either is clear.
- R10: Writes to the COUNT word are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timer clock |
| rst_i | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Register access strobe, one cycle per access |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 3 | Word address |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Registered overflow interrupt |

## Verification
On every cycle, assertions check that the running count steps by one, holds when stopped, is reloaded or zeroed as auto-reload dictates on overflow, and that the flag survives a same-edge clear while the interrupt tracks the flag and its enable. The absolute event timing from a start write, the three-cycle write latency seen through read-back, the exact periodic spacing and the ignored write to COUNT can only be shown by the bench's directed scenarios, which measure edges between register writes and irq_o.

// File: rtl/gp_evt_timer_pkg.sv
package gp_evt_timer_pkg;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_LOAD   = 3'd1;
  localparam logic [ADDR_W-1:0] A_RELOAD = 3'd2;
  localparam logic [ADDR_W-1:0] A_COUNT  = 3'd3;
  localparam logic [ADDR_W-1:0] A_IEN    = 3'd4;
  localparam logic [ADDR_W-1:0] A_STATUS = 3'd5;

  localparam int unsigned B_RUN  = 0;
  localparam int unsigned B_AUTO = 1;
  localparam int unsigned B_OVF  = 0;
  localparam int unsigned B_IEN  = 0;
endpackage

// File: rtl/gp_evt_timer_cmd_pipe.sv
module gp_evt_timer_cmd_pipe #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LAT    = 3
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              in_vld_i,
  input  logic              in_ctrl_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              out_vld_o,
  output logic              out_ctrl_o,
  output logic [DATA_W-1:0] out_data_o
);
  localparam int unsigned LAST = LAT - 1;

  logic              vld_q  [LAT];
  logic              ctrl_q [LAT];
  logic [DATA_W-1:0] data_q [LAT];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      vld_q[0]  <= 1'b0;
      ctrl_q[0] <= 1'b0;
      data_q[0] <= '0;
    end else begin
      vld_q[0]  <= in_vld_i;
      ctrl_q[0] <= in_ctrl_i;
      data_q[0] <= in_data_i;
    end
  end

  for (genvar s = 1; s < LAT; s++) begin : g_stage
    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        vld_q[s]  <= 1'b0;
        ctrl_q[s] <= 1'b0;
        data_q[s] <= '0;
      end else begin
        vld_q[s]  <= vld_q[s-1];
        ctrl_q[s] <= ctrl_q[s-1];
        data_q[s] <= data_q[s-1];
      end
    end
  end

  assign out_vld_o  = vld_q[LAST];
  assign out_ctrl_o = ctrl_q[LAST];
  assign out_data_o = data_q[LAST];
endmodule

// File: rtl/gp_evt_timer_core.sv
module gp_evt_timer_core #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             cmd_vld_i,
  input  logic             cmd_ctrl_i,
  input  logic [CNT_W-1:0] cmd_data_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] count_o,
  output logic             run_o,
  output logic             auto_o,
  output logic             ovf_evt_o
);
  import gp_evt_timer_pkg::*;

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] count_q;
  logic             run_q;
  logic             auto_q;
  logic             at_max;

  assign at_max    = (count_q == CNT_MAX);
  assign ovf_evt_o = run_q && !cmd_vld_i && at_max;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      count_q <= '0;
      run_q   <= 1'b0;
      auto_q  <= 1'b0;
    end else if (cmd_vld_i) begin
      if (cmd_ctrl_i) begin
        run_q  <= cmd_data_i[B_RUN];
        auto_q <= cmd_data_i[B_AUTO];
      end else begin
        count_q <= cmd_data_i;
      end
    end else if (run_q) begin
      if (at_max) begin
        if (auto_q) begin
          count_q <= reload_i;
        end else begin
          count_q <= '0;
          run_q   <= 1'b0;
        end
      end else begin
        count_q <= count_q + 1'b1;
      end
    end
  end

  assign count_o = count_q;
  assign run_o   = run_q;
  assign auto_o  = auto_q;

  // R2: a running count with no pending command steps by exactly one
  a_r2_step: assert property (@(posedge clk_i) disable iff (rst_i)
    (run_q && !cmd_vld_i && !at_max) |=> (count_q == $past(count_q) + 1'b1));

  // R3: one-shot overflow stops the timer at zero
  a_r3_oneshot_stop: assert property (@(posedge clk_i) disable iff (rst_i)
    (ovf_evt_o && !auto_q) |=> (!run_q && count_q == '0));

  // R4: periodic overflow restores the reload value
  a_r4_reload: assert property (@(posedge clk_i) disable iff (rst_i)
    (ovf_evt_o && auto_q) |=> (run_q && count_q == $past(reload_i)));

  // R6: a stopped timer holds its count
  a_r6_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    (!run_q && !cmd_vld_i) |=> $stable(count_q));
endmodule

// File: rtl/gp_evt_timer_regs.sv
module gp_evt_timer_regs #(
  parameter int unsigned DATA_W = 32
) (
  input  logic                                clk_i,
  input  logic                                rst_i,
  input  logic                                req_valid_i,
  input  logic                                req_write_i,
  input  logic [gp_evt_timer_pkg::ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0]                   req_wdata_i,
  input  logic [DATA_W-1:0]                   count_i,
  input  logic                                run_i,
  input  logic                                auto_i,
  input  logic                                ovf_evt_i,
  output logic                                cmd_vld_o,
  output logic                                cmd_ctrl_o,
  output logic [DATA_W-1:0]                   reload_o,
  output logic                                rsp_valid_o,
  output logic [DATA_W-1:0]                   rsp_rdata_o,
  output logic                                irq_o
);
  import gp_evt_timer_pkg::*;

  logic [DATA_W-1:0] reload_q;
  logic [DATA_W-1:0] load_q;
  logic              ien_q;
  logic              ovf_q;
  logic              irq_q;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rd_mux;
  logic              wr;
  logic              clr;

  assign wr         = req_valid_i && req_write_i;
  assign clr        = wr && (req_addr_i == A_STATUS) && req_wdata_i[B_OVF];
  assign cmd_vld_o  = wr && ((req_addr_i == A_CTRL) || (req_addr_i == A_LOAD));
  assign cmd_ctrl_o = (req_addr_i == A_CTRL);

  always_comb begin
    rd_mux = '0;
    case (req_addr_i)
      A_CTRL: begin
        rd_mux[B_RUN]  = run_i;
        rd_mux[B_AUTO] = auto_i;
      end
      A_LOAD:   rd_mux = load_q;
      A_RELOAD: rd_mux = reload_q;
      A_COUNT:  rd_mux = count_i;
      A_IEN:    rd_mux[B_IEN] = ien_q;
      A_STATUS: rd_mux[B_OVF] = ovf_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      reload_q    <= '0;
      load_q      <= '0;
      ien_q       <= 1'b0;
      ovf_q       <= 1'b0;
      irq_q       <= 1'b0;
      rsp_valid_q <= 1'b0;
      rdata_q     <= '0;
    end else begin
      if (wr && req_addr_i == A_RELOAD) reload_q <= req_wdata_i;
      if (wr && req_addr_i == A_LOAD)   load_q   <= req_wdata_i;
      if (wr && req_addr_i == A_IEN)    ien_q    <= req_wdata_i[B_IEN];
      if (ovf_evt_i)  ovf_q <= 1'b1;
      else if (clr)   ovf_q <= 1'b0;
      irq_q       <= ovf_q && ien_q;
      rsp_valid_q <= req_valid_i && !req_write_i;
      if (req_valid_i && !req_write_i) rdata_q <= rd_mux;
    end
  end

  assign reload_o    = reload_q;
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rdata_q;
  assign irq_o       = irq_q;

  // R8: an overflow on the clearing edge keeps the flag set
  a_r8_ovf_wins: assert property (@(posedge clk_i) disable iff (rst_i)
    ovf_evt_i |=> ovf_q);

  // R7: a clear with no overflow empties the flag
  a_r7_w1c: assert property (@(posedge clk_i) disable iff (rst_i)
    (clr && !ovf_evt_i) |=> !ovf_q);

  // R9: interrupt follows flag and enable one cycle later
  a_r9_irq_on: assert property (@(posedge clk_i) disable iff (rst_i)
    (ovf_q && ien_q) |=> irq_o);
  a_r9_irq_off: assert property (@(posedge clk_i) disable iff (rst_i)
    !(ovf_q && ien_q) |=> !irq_o);
endmodule

// File: rtl/gp_evt_timer.sv
module gp_evt_timer #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LAT    = 3
) (
  input  logic                                clk_i,
  input  logic                                rst_i,
  input  logic                                req_valid_i,
  input  logic                                req_write_i,
  input  logic [gp_evt_timer_pkg::ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0]                   req_wdata_i,
  output logic                                rsp_valid_o,
  output logic [DATA_W-1:0]                   rsp_rdata_o,
  output logic                                irq_o
);
  logic              in_vld;
  logic              in_ctrl;
  logic              cmd_vld;
  logic              cmd_ctrl;
  logic [DATA_W-1:0] cmd_data;
  logic [DATA_W-1:0] reload;
  logic [DATA_W-1:0] count;
  logic              run;
  logic              auto_rl;
  logic              ovf_evt;

  gp_evt_timer_regs #(.DATA_W(DATA_W)) regs_i (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .count_i     (count),
    .run_i       (run),
    .auto_i      (auto_rl),
    .ovf_evt_i   (ovf_evt),
    .cmd_vld_o   (in_vld),
    .cmd_ctrl_o  (in_ctrl),
    .reload_o    (reload),
    .rsp_valid_o (rsp_valid_o),
    .rsp_rdata_o (rsp_rdata_o),
    .irq_o       (irq_o)
  );

  gp_evt_timer_cmd_pipe #(.DATA_W(DATA_W), .LAT(LAT)) pipe_i (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .in_vld_i   (in_vld),
    .in_ctrl_i  (in_ctrl),
    .in_data_i  (req_wdata_i),
    .out_vld_o  (cmd_vld),
    .out_ctrl_o (cmd_ctrl),
    .out_data_o (cmd_data)
  );

  gp_evt_timer_core #(.CNT_W(DATA_W)) core_i (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .cmd_vld_i  (cmd_vld),
    .cmd_ctrl_i (cmd_ctrl),
    .cmd_data_i (cmd_data),
    .reload_i   (reload),
    .count_o    (count),
    .run_o      (run),
    .auto_o     (auto_rl),
    .ovf_evt_o  (ovf_evt)
  );
endmodule

// File: tb/gp_evt_timer_tb_top.sv
module gp_evt_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        vld = 1'b0;
  logic        wen = 1'b0;
  logic [2:0]  adr = '0;
  logic [31:0] wdat = '0;
  logic        rvld;
  logic [31:0] rdat;
  logic        irq;
  int          total = 0;
  int          bad = 0;
  int          cyc = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  gp_evt_timer dut_i (
    .clk_i(clk), .rst_i(rst), .req_valid_i(vld), .req_write_i(wen),
    .req_addr_i(adr), .req_wdata_i(wdat), .rsp_valid_o(rvld),
    .rsp_rdata_o(rdat), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    vld = 1'b1; wen = 1'b1; adr = a; wdat = d;
    @(negedge clk);
    vld = 1'b0; wen = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    vld = 1'b1; wen = 1'b0; adr = a;
    @(negedge clk);
    vld = 1'b0;
    d = rdat;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_irq(input logic lvl);
    for (int i = 0; i < 500 && irq !== lvl; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk(irq === 1'b0, "R1 irq", {31'd0, irq}, 0);
    for (int a = 0; a < 6; a++) begin
      rd(a[2:0], v);
      chk(v === 0, "R1 reset value", v, 0);
    end
  endtask

  task automatic t_latency();
    logic [31:0] v;
    wr(3'd1, 32'h0000_1234);
    for (int i = 0; i < 3; i++) begin
      rd(3'd3, v);
      chk(v === 0, "R5 old count during latency", v, 0);
    end
    rd(3'd3, v);
    chk(v === 32'h1234, "R5 new count after latency", v, 32'h1234);
    wr(3'd3, 32'h0000_0777);
    idle(5);
    rd(3'd3, v);
    chk(v === 32'h1234, "R10 count write ignored", v, 32'h1234);
  endtask

  task automatic t_oneshot();
    logic [31:0] v;
    int t0;
    wr(3'd4, 32'd1);
    wr(3'd1, 32'hFFFF_FFFF - 32'd10);
    wr(3'd0, 32'd1);
    t0 = cyc;
    wait_irq(1'b1);
    chk(cyc - t0 == 15, "R3 one-shot irq timing", cyc - t0, 15);
    rd(3'd3, v);
    chk(v === 0, "R3 count zero after one-shot", v, 0);
    idle(3);
    rd(3'd3, v);
    chk(v === 0, "R3 timer stopped", v, 0);
    rd(3'd0, v);
    chk(v === 0, "R3 run bit cleared", v, 0);
    wr(3'd5, 32'd0);
    rd(3'd5, v);
    chk(v === 1, "R7 write zero keeps flag", v, 1);
    wr(3'd5, 32'd1);
    rd(3'd5, v);
    chk(v === 0, "R7 write one clears flag", v, 0);
    idle(1);
    chk(irq === 1'b0, "R9 irq drops after clear", {31'd0, irq}, 0);
  endtask

  task automatic t_ien();
    logic [31:0] v;
    wr(3'd4, 32'd0);
    wr(3'd1, 32'hFFFF_FFFF - 32'd5);
    wr(3'd0, 32'd1);
    idle(20);
    rd(3'd5, v);
    chk(v === 1, "R9 flag set while disabled", v, 1);
    chk(irq === 1'b0, "R9 irq masked", {31'd0, irq}, 0);
    wr(3'd4, 32'd1);
    chk(irq === 1'b0, "R9 irq registered delay", {31'd0, irq}, 0);
    idle(1);
    chk(irq === 1'b1, "R9 irq after enable", {31'd0, irq}, 1);
    wr(3'd5, 32'd1);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    wr(3'd1, 32'hFFFF_FFFF - 32'd10);
    wr(3'd0, 32'd1);
    idle(13);
    wr(3'd5, 32'd1);
    rd(3'd5, v);
    chk(v === 1, "R8 overflow beats clear", v, 1);
    wr(3'd5, 32'd1);
    rd(3'd5, v);
    chk(v === 0, "R7 later clear works", v, 0);
  endtask

  task automatic t_periodic();
    int t1;
    logic [31:0] r;
    r = 32'hFFFF_FFFF - 32'd19;
    wr(3'd2, r);
    wr(3'd1, r);
    wr(3'd0, 32'd3);
    wait_irq(1'b1);
    t1 = cyc;
    wr(3'd5, 32'd1);
    wait_irq(1'b0);
    wait_irq(1'b1);
    chk(cyc - t1 == 20, "R4 periodic spacing", cyc - t1, 20);
    t1 = cyc;
    wr(3'd5, 32'd1);
    wait_irq(1'b0);
    wait_irq(1'b1);
    chk(cyc - t1 == 20, "R4 periodic spacing repeat", cyc - t1, 20);
    wr(3'd0, 32'd0);
    idle(4);
    wr(3'd5, 32'd1);
  endtask

  task automatic t_live_stop();
    logic [31:0] a, b, c, d;
    wr(3'd1, 32'h0000_0100);
    wr(3'd0, 32'd1);
    idle(6);
    rd(3'd3, a);
    rd(3'd3, b);
    chk(b === a + 1, "R2 live count step", b, a + 1);
    chk(a > 32'h100, "R2 counting upward", a, 32'h101);
    wr(3'd0, 32'd0);
    idle(4);
    rd(3'd3, c);
    idle(6);
    rd(3'd3, d);
    chk(c === d, "R6 count frozen after stop", d, c);
    chk(c > b, "R6 count kept not cleared", c, b + 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_latency();
    t_oneshot();
    t_ien();
    t_collide();
    t_periodic();
    t_live_stop();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule